// File: doc/BRIEF.md
# Previous-Sample Sum and Product Detector

This block watches a stream of 2-bit unsigned samples. Each clock it accepts a sample, pairs it with the sample it accepted last, and raises two flags in the same cycle. The first flag shows that the two values add up to more than two. The second shows that their product is more than two. It is a Mealy machine: the flags follow the present input and the stored value combinationally, and only the stored value is registered.

Samples come in on `smp_val` and `smp_n`. The block has no ready signal and never applies back-pressure, so any cycle with `smp_val` high is taken. A cycle with `smp_val` low is a bubble. During a bubble both flags stay low and the stored value does not change. After a synchronous reset the stored value is zero. The first sample after reset is therefore compared with zero.

Top module: `psd_detector`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the stored previous value to 0. The first valid sample after reset is compared with 0.
- R2: While `smp_val` is high, `hit_sum` is 1 exactly when `smp_n` plus the stored previous value is greater than 2. `smp_n` is unsigned, with bit 1 as the MSB.
- R3: While `smp_val` is high, `hit_prod` is 1 exactly when `smp_n` times the stored previous value is greater than 2.
- R4: While `smp_val` is low, `hit_sum` and `hit_prod` are both 0 whatever `smp_n` is.
- R5: A rising edge with `smp_val` high and `rst` low stores `smp_n` as the new previous value.
- R6: A rising edge with `smp_val` low and `rst` low keeps the stored value. Any number of bubbles leaves the next valid sample's comparison unchanged.
- R7: Both flags answer the present input in the same cycle, with no added clock of latency.
- R8: `hit_prod` is never 1 while `hit_sum` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_val | input | 1 | Sample valid strobe |
| smp_n | input | 2 | Unsigned sample value |
| hit_sum | output | 1 | Present plus previous is greater than 2 |
| hit_prod | output | 1 | Present times previous is greater than 2 |

## Verification
The assertions are evaluated on every cycle. They cover the quiet flags during bubbles, that the product flag implies the sum flag, the capture of each valid sample, the hold through bubbles, the clear on reset, and both flag functions against a shadow copy of the last accepted sample. The directed scenarios cover the rest. They apply all sixteen pairs of previous and present values, reset in the middle of a run, and insert long runs of bubbles that drive changing data. Only these runs show that bubbles leave the next comparison unchanged and that the answer arrives with no added latency.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned DATA_W  = 2;
  localparam int unsigned SUM_W   = DATA_W + 1;
  localparam int unsigned PROD_W  = 2 * DATA_W;
  localparam int unsigned SUM_LIM  = 2;
  localparam int unsigned PROD_LIM = 2;

  typedef logic [DATA_W-1:0] smp_t;

  typedef struct packed {
    logic sum_gt;
    logic prod_gt;
  } hits_t;
endpackage

// File: rtl/psd_prev_reg.sv
module psd_prev_reg
  import psd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  smp_t cap_d,
  output smp_t prev_q
);
  always_ff @(posedge clk) begin
    if (rst)         prev_q <= '0;
    else if (cap_en) prev_q <= cap_d;
  end
endmodule

// File: rtl/psd_eval.sv
module psd_eval
  import psd_pkg::*;
(
  input  smp_t  cur,
  input  smp_t  prev,
  output hits_t hits
);
  logic [SUM_W-1:0]  sum_v;
  logic [PROD_W-1:0] prod_v;

  always_comb begin
    sum_v  = SUM_W'(cur) + SUM_W'(prev);
    prod_v = PROD_W'(cur) * PROD_W'(prev);
    hits.sum_gt  = (sum_v  > SUM_W'(SUM_LIM));
    hits.prod_gt = (prod_v > PROD_W'(PROD_LIM));
  end
endmodule

// File: rtl/psd_gate.sv
module psd_gate
  import psd_pkg::*;
(
  input  logic  en,
  input  hits_t raw,
  output hits_t gated
);
  always_comb begin
    gated.sum_gt  = en & raw.sum_gt;
    gated.prod_gt = en & raw.prod_gt;
  end
endmodule

// File: rtl/psd_detector.sv
module psd_detector
  import psd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_val,
  input  logic [DATA_W-1:0] smp_n,
  output logic              hit_sum,
  output logic              hit_prod
);
  smp_t  prev_q;
  hits_t raw_hits;
  hits_t out_hits;

  psd_prev_reg u_prev (
    .clk    (clk),
    .rst    (rst),
    .cap_en (smp_val),
    .cap_d  (smp_n),
    .prev_q (prev_q)
  );

  psd_eval u_eval (
    .cur  (smp_n),
    .prev (prev_q),
    .hits (raw_hits)
  );

  psd_gate u_gate (
    .en    (smp_val),
    .raw   (raw_hits),
    .gated (out_hits)
  );

  assign hit_sum  = out_hits.sum_gt;
  assign hit_prod = out_hits.prod_gt;
endmodule

// File: rtl/psd_detector_chk.sv
module psd_detector_chk
  import psd_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic smp_val,
  input smp_t smp_n,
  input logic hit_sum,
  input logic hit_prod,
  input smp_t prev_q
);
  smp_t shadow;
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)          shadow <= '0;
    else if (smp_val) shadow <= smp_n;
  end

  a_r4_bubble_quiet: assert property (@(posedge clk) disable iff (rst)
    !smp_val |-> (!hit_sum && !hit_prod));

  a_r8_prod_implies_sum: assert property (@(posedge clk) disable iff (rst)
    hit_prod |-> hit_sum);

  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    smp_val |=> (prev_q == $past(smp_n)));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_val |=> $stable(prev_q));

  a_r2_sum_fn: assert property (@(posedge clk) disable iff (rst || rst_d !== 1'b0)
    smp_val |-> (hit_sum == ((3'(smp_n) + 3'(shadow)) > 3'd2)));

  a_r3_prod_fn: assert property (@(posedge clk) disable iff (rst || rst_d !== 1'b0)
    smp_val |-> (hit_prod == ((4'(smp_n) * 4'(shadow)) > 4'd2)));

  always @(negedge clk) begin
    if (rst_d === 1'b1)
      a_r1_cleared: assert (prev_q == '0);
  end
endmodule

bind psd_detector psd_detector_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_val  (smp_val),
  .smp_n    (smp_n),
  .hit_sum  (hit_sum),
  .hit_prod (hit_prod),
  .prev_q   (prev_q)
);

// File: tb/test_psd_detector.sv
module test_psd_detector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_val = 1'b0;
  logic [1:0] smp_n = 2'd0;
  logic       hit_sum, hit_prod;

  int n_chk = 0;
  int n_bad = 0;
  int ref_prev = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  psd_detector i_psd_detector (
    .clk(clk), .rst(rst), .smp_val(smp_val), .smp_n(smp_n),
    .hit_sum(hit_sum), .hit_prod(hit_prod)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive one cycle mid-period, check the flags in that cycle (R7), and let the edge capture.
  task automatic step(input logic v, input int n, input string req);
    logic es, ep;
    @(negedge clk);
    smp_val = v;
    smp_n = 2'(n);
    #1;
    es = v && ((n + ref_prev) > 2);
    ep = v && ((n * ref_prev) > 2);
    check({req, " sum"}, hit_sum, es);
    check({req, " prod"}, hit_prod, ep);
    if (v) ref_prev = n;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_val = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    ref_prev = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    step(1'b0, 3, "R4 idle after reset");
    step(1'b1, 3, "R1 first sample vs zero");
    step(1'b1, 3, "R3 three times three");
  endtask

  task automatic t_all_pairs();
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        step(1'b1, a, "R5 load previous");
        step(1'b1, b, "R2/R3 pair");
      end
  endtask

  task automatic t_bubbles();
    step(1'b1, 3, "R5 load three");
    for (int i = 0; i < 6; i++) step(1'b0, i % 4, "R4 bubble");
    step(1'b1, 1, "R6 held value used");
    step(1'b1, 2, "R6 one then two");
  endtask

  task automatic t_mid_reset();
    step(1'b1, 3, "R5 load three");
    do_reset();
    step(1'b1, 2, "R1 reset mid-run");
    step(1'b1, 2, "R2 two plus two");
  endtask

  task automatic t_run();
    int seq[10] = '{1, 1, 2, 0, 3, 1, 2, 2, 0, 1};
    foreach (seq[i]) step((i % 3) != 2, seq[i], "R7 mixed run");
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_all_pairs();
        t_bubbles();
        t_mid_reset();
        t_run();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule